// File: doc/BRIEF.md
# Dual-Context Sensor Parameter Switcher

This block keeps two complete banks of sensor operating parameters, context A and context B. Each bank holds one integration time and a set of other readout parameters: line length, frame length, binning, gains, window bounds and similar values. The block presents one active set to the readout timing logic. A host fills either bank through a plain write port. It chooses the context with a single select bit, which it may flip at any moment.

Changes reach the outputs only on frame boundaries, and they follow a staggered rule. When a new context is seen at a frame start, the integration time of the new bank drives the output from that frame on. All other parameters of the new bank follow one frame later. The exposure of a frame is therefore set up before the readout geometry that belongs with it. The rule is the same for A-to-B and B-to-A switches. A write to the bank that is already active is also held back until the next frame start.

The write port has no back-pressure: every write strobe is taken in the cycle it appears. The select bit and the frame-start pulse are plain control pins.

Top module: `dual_ctx_param_bank`

## Requirements
- R1: After reset both banks hold zero, both the integration-time context and the parameter context are A, and `act_it` and `act_par` read zero.
- R2: A cycle with `wr_en` high always writes bank `wr_bank` (0 = A, 1 = B). Address 0 stores `wr_data[ITW-1:0]` as the integration time. Address k, for 1 <= k <= NPAR, stores `wr_data[PW-1:0]` as parameter k-1. Parameter i appears on `act_par[i*PW +: PW]`.
- R3: A write to an address above NPAR changes no bank and no output.
- R4: `ctx_sel` is sampled only in cycles where `frame_start` is high. A toggle that returns to the old value before the next frame start causes no switch.
- R5: Suppose no update is pending, and `ctx_sel` sampled at a frame start differs from the current integration-time context. Then, from that frame start, `act_it` comes from the newly selected bank. This holds in both directions.
- R6: At the frame start that follows an integration-time switch, `act_par` switches to the bank that the integration time already uses.
- R7: At the frame start where a pending parameter switch completes, `ctx_sel` is not acted on. A differing select value is taken at the following frame start.
- R8: `act_it` and `act_par` change only on the clock edge of a `frame_start` cycle. At each frame start they reload from their bank's current contents, so a write to an active bank first shows at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| ctx_sel | input | 1 | Requested context, 0 = A, 1 = B |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_bank | input | 1 | Bank written, 0 = A, 1 = B |
| wr_addr | input | $clog2(NPAR+1) | 0 = integration time, 1..NPAR = parameter index plus one |
| wr_data | input | max(ITW,PW) | Write data, low bits used |
| act_it | output | ITW | Active integration time |
| act_par | output | NPAR*PW | Active other parameters, parameter i at bits i*PW |

## Verification
The select bit is swept over every 6-frame sequence of per-frame values. This covers plain switches and switches in both directions. It also covers requests that land on the frame where a pending parameter update completes, which separates a correct deferral from a design that acts on every frame start. Within each frame the select bit is glitched and then restored. This shows whether the bit is sampled only at the frame start. A write to a rotating bank and address is also made in each frame, and the outputs are checked before that frame ends. This separates held outputs from outputs that track writes mid-frame. Out-of-range addresses are part of the rotation and must leave every value untouched.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic {
    CTX_A = 1'b0,
    CTX_B = 1'b1
  } ctx_e;
endpackage

// File: rtl/ctx_bank.sv
module ctx_bank #(
  parameter int  ITW     = 12,
  parameter int  PW      = 8,
  parameter int  NPAR    = 4,
  parameter int  AW      = 3,
  parameter int  DW      = 12,
  parameter bit  BANK_ID = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_bank,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [ITW-1:0]      it_q,
  output logic [NPAR*PW-1:0]  par_q
);
  logic hit;
  assign hit = wr_en && (wr_bank == BANK_ID);

  always_ff @(posedge clk) begin
    if (!rst_n)                        it_q <= '0;
    else if (hit && wr_addr == '0)     it_q <= wr_data[ITW-1:0];
  end

  for (genvar k = 0; k < NPAR; k++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)                                   par_q[k*PW +: PW] <= '0;
      else if (hit && wr_addr == AW'(k + 1))        par_q[k*PW +: PW] <= wr_data[PW-1:0];
    end
  end

  assert_it_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_addr == '0) |=> (it_q == $past(wr_data[ITW-1:0])));

  assert_bad_addr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) > NPAR)) |=> ($stable(it_q) && $stable(par_q)));
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
  import ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic ctx_sel,
  output ctx_e it_ctx,
  output ctx_e par_ctx,
  output ctx_e it_ctx_nxt,
  output ctx_e par_ctx_nxt
);
  logic pending;
  assign pending = (it_ctx != par_ctx);

  always_comb begin
    it_ctx_nxt  = it_ctx;
    par_ctx_nxt = par_ctx;
    if (frame_start) begin
      if (pending)                        par_ctx_nxt = it_ctx;
      else if (ctx_e'(ctx_sel) != it_ctx) it_ctx_nxt  = ctx_e'(ctx_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      it_ctx  <= CTX_A;
      par_ctx <= CTX_A;
    end else begin
      it_ctx  <= it_ctx_nxt;
      par_ctx <= par_ctx_nxt;
    end
  end

  assert_it_ctx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(it_ctx));

  assert_it_takes_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (it_ctx == par_ctx) && (ctx_sel != it_ctx)) |=> (it_ctx == ctx_e'($past(ctx_sel))));

  assert_par_follows_it_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (it_ctx != par_ctx)) |=> (par_ctx == $past(it_ctx)));

  assert_par_ctx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(par_ctx));

  assert_defer_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (it_ctx != par_ctx)) |=> $stable(it_ctx));
endmodule

// File: rtl/ctx_shadow.sv
module ctx_shadow
  import ctx_pkg::*;
#(
  parameter int ITW  = 12,
  parameter int PW   = 8,
  parameter int NPAR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  ctx_e               it_sel,
  input  ctx_e               par_sel,
  input  logic [ITW-1:0]     it_a,
  input  logic [ITW-1:0]     it_b,
  input  logic [NPAR*PW-1:0] par_a,
  input  logic [NPAR*PW-1:0] par_b,
  output logic [ITW-1:0]     act_it,
  output logic [NPAR*PW-1:0] act_par
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_it  <= '0;
      act_par <= '0;
    end else if (load) begin
      act_it  <= (it_sel  == CTX_B) ? it_b  : it_a;
      act_par <= (par_sel == CTX_B) ? par_b : par_a;
    end
  end

  assert_hold_between_frames_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_it) && $stable(act_par)));
endmodule

// File: rtl/dual_ctx_param_bank.sv
module dual_ctx_param_bank
  import ctx_pkg::*;
#(
  parameter int ITW  = 12,
  parameter int PW   = 8,
  parameter int NPAR = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    frame_start,
  input  logic                                    ctx_sel,
  input  logic                                    wr_en,
  input  logic                                    wr_bank,
  input  logic [$clog2(NPAR+1)-1:0]               wr_addr,
  input  logic [((ITW > PW) ? ITW : PW)-1:0]      wr_data,
  output logic [ITW-1:0]                          act_it,
  output logic [NPAR*PW-1:0]                      act_par
);
  localparam int AW = $clog2(NPAR + 1);
  localparam int DW = (ITW > PW) ? ITW : PW;

  logic [ITW-1:0]     it_q   [2];
  logic [NPAR*PW-1:0] par_q  [2];
  ctx_e               it_ctx, par_ctx, it_ctx_nxt, par_ctx_nxt;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ctx_bank #(
      .ITW(ITW), .PW(PW), .NPAR(NPAR), .AW(AW), .DW(DW), .BANK_ID(b[0])
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_addr(wr_addr), .wr_data(wr_data), .it_q(it_q[b]), .par_q(par_q[b])
    );
  end

  ctx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctx_sel(ctx_sel),
    .it_ctx(it_ctx), .par_ctx(par_ctx),
    .it_ctx_nxt(it_ctx_nxt), .par_ctx_nxt(par_ctx_nxt)
  );

  ctx_shadow #(.ITW(ITW), .PW(PW), .NPAR(NPAR)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .it_sel(it_ctx_nxt), .par_sel(par_ctx_nxt),
    .it_a(it_q[0]), .it_b(it_q[1]), .par_a(par_q[0]), .par_b(par_q[1]),
    .act_it(act_it), .act_par(act_par)
  );

  // R1: reset leaves both contexts at A
  assert_reset_ctx_R1: assert property (@(posedge clk)
    !rst_n |=> (it_ctx == CTX_A && par_ctx == CTX_A));
endmodule

// File: tb/dual_ctx_param_bank_tb.sv
module dual_ctx_param_bank_tb;
  localparam int ITW  = 12;
  localparam int PW   = 8;
  localparam int NPAR = 4;
  localparam int AW   = 3;
  localparam int DW   = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, frame_start, ctx_sel, wr_en, wr_bank;
  logic [AW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;
  logic [ITW-1:0]    act_it;
  logic [NPAR*PW-1:0] act_par;

  dual_ctx_param_bank #(.ITW(ITW), .PW(PW), .NPAR(NPAR)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctx_sel(ctx_sel),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_it(act_it), .act_par(act_par)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [ITW-1:0] m_it  [2];
  logic [PW-1:0]  m_par [2][NPAR];
  int             ic, pc;
  logic [ITW-1:0] e_it;
  logic [PW-1:0]  e_par [NPAR];

  task automatic chk_out(input string tag);
    vectors++;
    if (act_it !== e_it) begin
      errors++;
      $display("FAIL %s act_it got %0h expected %0h", tag, act_it, e_it);
    end
    for (int i = 0; i < NPAR; i++) begin
      vectors++;
      if (act_par[i*PW +: PW] !== e_par[i]) begin
        errors++;
        $display("FAIL %s act_par[%0d] got %0h expected %0h", tag, i, act_par[i*PW +: PW], e_par[i]);
      end
    end
  endtask

  // R2 and R3: model of the write decode
  task automatic do_write(input int bank, input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_bank = bank[0];
    wr_addr = AW'(addr);
    wr_data = DW'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (addr == 0)          m_it[bank] = ITW'(data);
    else if (addr <= NPAR)  m_par[bank][addr-1] = PW'(data);
  endtask

  // R5, R6, R7: staggered switch model evaluated at a frame start
  task automatic frame_end(input bit s);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (ic != pc)        pc = ic;
    else if (int'(s) != ic) ic = int'(s);
    e_it = m_it[ic];
    for (int i = 0; i < NPAR; i++) e_par[i] = m_par[pc][i];
    chk_out("R5 R6 R7 R8 frame-start");
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; ctx_sel = 1'b0;
    wr_en = 1'b0; wr_bank = 1'b0; wr_addr = '0; wr_data = '0;
    ic = 0; pc = 0; e_it = '0;
    for (int b = 0; b < 2; b++) begin
      m_it[b] = '0;
      for (int i = 0; i < NPAR; i++) m_par[b][i] = '0;
    end
    for (int i = 0; i < NPAR; i++) e_par[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 reset");

    // R2: load both banks with distinct values before any frame start
    for (int b = 0; b < 2; b++)
      for (int a = 0; a <= NPAR; a++)
        do_write(b, a, 16 * (b + 1) + a * 3 + 1);
    chk_out("R8 writes before first frame start");
    frame_end(1'b0);

    for (int pat = 0; pat < 64; pat++) begin
      for (int k = 0; k < 6; k++) begin
        bit s;
        s = pat[k];
        // R4: glitch the select bit, then restore it before the frame start
        @(negedge clk);
        ctx_sel = ~s;
        @(negedge clk);
        ctx_sel = s;
        // R3: addresses 5..7 land in this rotation and must be ignored
        do_write((pat + k) & 1, (pat * 3 + k) % 8, (pat * 37 + k * 101 + 5) & 12'hfff);
        chk_out("R8 R4 mid-frame hold");
        frame_end(s);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule